// File: doc/BRIEF.md
# Data-Enable Activity Sync Detector

This block watches the data-enable strobe recovered from a video link, in the pixel clock domain. It drives one status bit, `sync_present`, that tells the rest of the system whether an active video stream is arriving. Display controllers use this bit for hot-plug decisions: they start the panel pipeline when the bit rises and shut it down when it falls.

The DE input first passes through a synchroniser chain. The detector then counts the high-to-low transitions of the synchronised strobe. The status bit asserts once `EDGE_TARGET` falling transitions have been counted. It deasserts in two cases: when the strobe stops changing for longer than `IDLE_CYCLES` clocks, or as soon as the link clock is reported invalid. Either event also empties the transition count, so the status bit rises again only after a full new run of `EDGE_TARGET` falls. The long release window and the separate assert count give the output hysteresis. With the defaults, the output asserts after 40 falls and releases after roughly 116 ms of inactivity at an 86 MHz pixel clock.

The `clk_valid` input is taken as synchronous to `clk`. The status output has no power-down gating.

Top module: `de_activity_detect`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `sync_present` is 0.
- R2: DE passes through `SYNC_STAGES` (default 2) flops before edge detection. With 2 stages, when a high-to-low change of `de_in` is the `EDGE_TARGET`-th counted fall, `sync_present` is still 0 after the 2nd rising clock edge that follows the change and is 1 after the 3rd.
- R3: With fewer than `EDGE_TARGET` falling transitions since the last clear, `sync_present` stays 0. Low-to-high transitions are not counted.
- R4: Once asserted, `sync_present` stays 1 for as long as consecutive `de_in` changes (of either direction) are at most `IDLE_CYCLES`+1 clocks apart and `clk_valid` stays 1.
- R5: When `de_in` stops changing, `sync_present` is still 1 after the (`IDLE_CYCLES`+3)-th rising clock edge following the last change and is 0 after the (`IDLE_CYCLES`+4)-th.
- R6: Edge detection and idle expiry can occur in the same clock. In that case the edge wins. A gap of exactly `IDLE_CYCLES`+1 clocks between changes keeps `sync_present` at 1. A gap of `IDLE_CYCLES`+2 clocks drops it.
- R7: Sampling `clk_valid` = 0 at a rising clock edge makes `sync_present` 0 after that edge. Falls of `de_in` that occur while `clk_valid` is 0 are not counted.
- R8: After any clear (idle expiry, `clk_valid` low, or reset), exactly `EDGE_TARGET` new falls are needed before `sync_present` rises again.
- R9: DE high or low phases as short as one clock are each detected, so any pattern of one-, two- or three-cycle phases asserts `sync_present` after `EDGE_TARGET` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_valid | input | 1 | Link clock reported good, synchronous to `clk` |
| de_in | input | 1 | Recovered data-enable strobe |
| sync_present | output | 1 | Active video link detected |

## Verification
Two events can land in the same clock: the idle timer reaching its limit, and a DE transition arriving from the synchroniser. The bench provokes this by spacing two DE changes exactly `IDLE_CYCLES`+1 clocks apart, so that the second edge is detected in the very cycle the timer would expire. It requires the status bit to survive that spacing. It also requires the bit to drop when the spacing is one clock longer. A `clk_valid` drop that coincides with falls in flight is judged the same way: the clear must win, and the full count must be redone afterwards.

// File: rtl/de_act_pkg.sv
package de_act_pkg;
   // bits needed to hold the values 0..n
   function automatic int cnt_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/de_act_sync.sv
module de_act_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic de_raw,
   output logic de_fall,
   output logic de_edge
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   last_q;
   logic                   de_s;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("de_act_sync: SYNC_STAGES must be at least 2");
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], de_raw};
         end
      end
   endgenerate

   assign de_s = chain_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= de_s;
   end

   assign de_fall = last_q & ~de_s;
   assign de_edge = last_q ^ de_s;
endmodule

// File: rtl/de_act_timer.sv
module de_act_timer #(
   parameter int IDLE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);
   import de_act_pkg::*;
   localparam int TW = cnt_bits(IDLE_CYCLES);
   localparam logic [TW-1:0] LIMIT = TW'(IDLE_CYCLES);

   logic [TW-1:0] cnt_q;

   generate
      if (IDLE_CYCLES < 2) begin : g_bad_idle
         $error("de_act_timer: IDLE_CYCLES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart)        cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/de_act_counter.sv
module de_act_counter #(
   parameter int EDGE_TARGET = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic fall,
   output logic reached
);
   import de_act_pkg::*;
   localparam int CW = cnt_bits(EDGE_TARGET);
   localparam logic [CW-1:0] GOAL = CW'(EDGE_TARGET);

   logic [CW-1:0] cnt_q;

   generate
      if (EDGE_TARGET < 1) begin : g_bad_target
         $error("de_act_counter: EDGE_TARGET must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clear)                 cnt_q <= '0;
      else if (fall && cnt_q != GOAL) cnt_q <= cnt_q + 1'b1;
   end

   assign reached = (cnt_q == GOAL);
endmodule

// File: rtl/de_activity_detect.sv
module de_activity_detect #(
   parameter int EDGE_TARGET = 40,
   parameter int IDLE_CYCLES = 10_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_valid,
   input  logic de_in,
   output logic sync_present
);
   logic fall_w;
   logic edge_w;
   logic expired_w;
   logic restart_w;
   logic clear_w;

   de_act_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .de_raw  (de_in),
      .de_fall (fall_w),
      .de_edge (edge_w)
   );

   // any strobe change, or a dead link clock, restarts the idle window
   assign restart_w = edge_w | ~clk_valid;

   de_act_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart_w),
      .expired (expired_w)
   );

   // an edge in the expiry cycle counts as activity, so it beats the timeout
   assign clear_w = ~clk_valid | (expired_w & ~edge_w);

   de_act_counter #(.EDGE_TARGET(EDGE_TARGET)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear_w),
      .fall    (fall_w),
      .reached (sync_present)
   );
endmodule

// File: rtl/de_activity_detect_chk.sv
module de_activity_detect_chk (
   input logic clk,
   input logic rst_n,
   input logic clk_valid,
   input logic sync_present,
   input logic fall,
   input logic de_edge,
   input logic expired
);
   // R7
   clkvalid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_valid |=> !sync_present);

   // R5
   idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !de_edge) |=> !sync_present);

   // R6
   edge_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_present && clk_valid && de_edge) |=> sync_present);

   // R3
   rise_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_present) |-> $past(fall && clk_valid));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_present && clk_valid && !expired) |=> sync_present);

   // R1
   reset_low_chk: assert property (@(posedge clk)
      !rst_n |-> !sync_present);
endmodule

bind de_activity_detect de_activity_detect_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clk_valid    (clk_valid),
   .sync_present (sync_present),
   .fall         (fall_w),
   .de_edge      (edge_w),
   .expired      (expired_w)
);

// File: tb/de_activity_detect_test.sv
module de_activity_detect_test;
   localparam int TGT  = 4;
   localparam int IDLE = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_valid = 1'b1;
   logic de_in = 1'b0;
   logic sync_present;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   de_activity_detect #(.EDGE_TARGET(TGT), .IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .clk_valid    (clk_valid),
      .de_in        (de_in),
      .sync_present (sync_present)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic exp);
      tests++;
      if (sync_present !== exp) begin
         fails++;
         $display("FAIL %s: sync_present=%b expected %b at %0t", req, sync_present, exp, $time);
      end
   endtask

   // one high phase then one low phase, inputs changed at negedges
   task automatic pulse(input int hi, input int lo);
      de_in = 1'b1; wait_n(hi);
      de_in = 1'b0; wait_n(lo);
   endtask

   // let the pipeline settle with DE low, then empty the count via clk_valid
   task automatic flush();
      de_in = 1'b0; wait_n(4);
      clk_valid = 1'b0; wait_n(1);
      clk_valid = 1'b1; wait_n(1);
   endtask

   initial begin
      wait_n(3);
      chk("R1 during reset", 1'b0);
      rst_n = 1'b1;
      wait_n(1);
      chk("R1 after release", 1'b0);

      // R3 / R8: sweep the fall count
      for (int k = 0; k <= TGT + 1; k++) begin
         flush();
         for (int p = 0; p < k; p++) pulse(2, 4);
         chk((k >= TGT) ? "R8 full run asserts" : "R3 short run stays low", (k >= TGT) ? 1'b1 : 1'b0);
      end

      // R3: rising changes alone are not counted
      flush();
      for (int p = 0; p < TGT - 1; p++) pulse(3, 3);
      de_in = 1'b1; wait_n(6);
      chk("R3 rise not counted", 1'b0);
      de_in = 1'b0; wait_n(4);
      chk("R3 final fall counted", 1'b1);

      // R9: short phases, exhaustive over widths 1..3
      for (int w = 1; w <= 3; w++) begin
         for (int l = 1; l <= 3; l++) begin
            flush();
            for (int p = 0; p < TGT - 1; p++) pulse(w, l);
            wait_n(4);
            chk("R9 one short of target", 1'b0);
            pulse(w, l);
            wait_n(4);
            chk("R9 short phases assert", 1'b1);
         end
      end

      // R2: exact assertion latency
      flush();
      for (int p = 0; p < TGT - 1; p++) pulse(2, 4);
      de_in = 1'b1; wait_n(4);
      de_in = 1'b0;
      wait_n(2);
      chk("R2 low after 2nd edge", 1'b0);
      wait_n(1);
      chk("R2 high after 3rd edge", 1'b1);

      // R5: exact release latency after the last change
      wait_n(IDLE);
      chk("R5 high after IDLE+3 edges", 1'b1);
      wait_n(1);
      chk("R5 low after IDLE+4 edges", 1'b0);

      // R4 / R6: gap of IDLE+1 survives
      flush();
      for (int p = 0; p < TGT - 1; p++) pulse(2, 4);
      de_in = 1'b1; wait_n(4);
      de_in = 1'b0;
      for (int g = 0; g < 4; g++) begin
         wait_n(IDLE + 1);
         de_in = ~de_in;
      end
      wait_n(4);
      chk("R6 gap IDLE+1 holds", 1'b1);
      chk("R4 steady activity holds", 1'b1);

      // R6: gap of IDLE+2 drops
      wait_n(IDLE + 2 - 4);
      de_in = ~de_in;
      wait_n(6);
      chk("R6 gap IDLE+2 drops", 1'b0);

      // R7: clk_valid low clears at once, falls while low are ignored
      flush();
      for (int p = 0; p < TGT; p++) pulse(2, 4);
      chk("R7 asserted before drop", 1'b1);
      clk_valid = 1'b0;
      wait_n(1);
      chk("R7 clk_valid low clears", 1'b0);
      for (int p = 0; p < TGT + 1; p++) pulse(2, 4);
      chk("R7 falls ignored while invalid", 1'b0);
      clk_valid = 1'b1;
      wait_n(2);
      chk("R7 stays low on return", 1'b0);
      for (int p = 0; p < TGT - 1; p++) pulse(2, 4);
      chk("R8 recount after clk_valid", 1'b0);
      pulse(2, 4);
      chk("R8 recount completes", 1'b1);

      // R1: reset mid-run forces low and empties the count
      rst_n = 1'b0;
      wait_n(1);
      chk("R1 reset mid-run", 1'b0);
      rst_n = 1'b1;
      for (int p = 0; p < TGT - 1; p++) pulse(2, 4);
      chk("R8 recount after reset", 1'b0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100_000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule